// File: doc/BRIEF.md
# Scanline-driven IRQ down-counter

This block raises an interrupt request to the CPU once a programmable number of rendered scanlines has gone by. The CPU programs it through four write addresses: one loads the running counter directly, one loads the reload value, one stops counting and one starts counting. Every one of these four writes also acknowledges a pending request and drops the IRQ line.

A video-timing source outside the block sends a one-clock pulse for each scanline. The pulse carries the scanline number and a flag that says whether rendering is on. The block counts only on visible scanlines while rendering is on, and only while it is enabled and no request is pending. When the count expires, the block sets the request, drives its level IRQ output high and reloads the counter from the reload value. The output stays high until the CPU writes one of the four addresses.

Top module: `scanline_irq_counter`

## Requirements
- R1: After reset the IRQ output is low and the counter, the reload value, the enable and the pending request are all zero. An enable followed by one counted scanline therefore raises the IRQ at once.
- R2: A write to 0xC000 loads the counter with the data byte, and a write to 0xC001 loads the reload value. Decoding masks the address with 0xF7FF, so 0xC800 and 0xC801 act the same way.
- R3: A write to any of 0xC000, 0xC001, 0xE000 or 0xE001 (mask 0xF7FF) clears a pending request, and the IRQ output is low from the next cycle.
- R4: A write to 0xE000 stops counting and a write to 0xE001 starts it. While stopped, scanline pulses change nothing.
- R5: A scanline pulse counts only when the scanline number is 0 to 239 and the rendering flag is high. Any other pulse is ignored.
- R6: On a counted scanline the counter is tested. If it is zero, the request is set, the IRQ output goes high in the next cycle and the counter reloads from the reload value. Otherwise the counter drops by one.
- R7: On scanline 0, a nonzero counter first takes one extra decrement before the test of R6. A counter of 1 therefore expires on scanline 0.
- R8: While a request is pending, scanline pulses do not count, and the IRQ stays high until a write from R3.
- R9: When a CPU write to one of the four addresses and a scanline pulse arrive in the same cycle, the write takes effect and the pulse is dropped.
- R10: Writes to addresses outside the four decoded ones (for example 0xA000 or 0xC002) change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_wr | input | 1 | CPU write strobe, one cycle per write |
| cpu_addr | input | 16 | CPU write address |
| cpu_wdata | input | 8 | CPU write data |
| line_tick | input | 1 | One-clock pulse per scanline |
| line_index | input | 9 | Scanline number that comes with line_tick |
| render_en | input | 1 | Rendering-enabled flag that comes with line_tick |
| irq_out | output | 1 | Level interrupt request |

## Verification
The bench aims at the scanline-0 extra decrement with counter values 1 and 3. A design without it would fire one scanline late, and a design that decremented from zero would wrap instead of expiring. It sends pulses while a request is pending, on scanline 240 and with rendering off. A design that counted there would fire early or reload a second time. It also drives a CPU write in the same cycle as a pulse, uses the address mirrors at bit 11, and writes to near-miss addresses. Wrong priority shows up as a shifted IRQ, a wrong mask as a missing load, and loose decoding as a spurious load.

// File: rtl/irq_ctr_pkg.sv
package irq_ctr_pkg;

  localparam int CNT_W = 8;

  typedef enum logic [2:0] {
    CMD_NONE,
    CMD_LOAD_CNT,
    CMD_LOAD_RELOAD,
    CMD_STOP,
    CMD_START
  } cpu_cmd_e;

  typedef struct packed {
    logic             expire;
    logic [CNT_W-1:0] next;
  } step_res_t;

  // Counter step: optional extra decrement on the first visible line,
  // then expiry test on the resulting value.
  function automatic step_res_t count_step(input logic [CNT_W-1:0] cur,
                                           input logic             first_line);
    step_res_t        r;
    logic [CNT_W-1:0] pre;
    pre      = (first_line && (cur != '0)) ? cur - 1'b1 : cur;
    r.expire = (pre == '0);
    r.next   = pre - 1'b1;
    return r;
  endfunction

endpackage

// File: rtl/irq_addr_decode.sv
module irq_addr_decode
  import irq_ctr_pkg::*;
#(
  parameter int               ADDR_W     = 16,
  parameter logic [ADDR_W-1:0] ADDR_MASK = 16'hF7FF,
  parameter logic [ADDR_W-1:0] A_CNT     = 16'hC000,
  parameter logic [ADDR_W-1:0] A_RELOAD  = 16'hC001,
  parameter logic [ADDR_W-1:0] A_STOP    = 16'hE000,
  parameter logic [ADDR_W-1:0] A_START   = 16'hE001
) (
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  output cpu_cmd_e          cmd
);

  logic [ADDR_W-1:0] masked;

  always_comb begin
    masked = addr & ADDR_MASK;
    cmd    = CMD_NONE;
    if (wr) begin
      if (masked == A_CNT)         cmd = CMD_LOAD_CNT;
      else if (masked == A_RELOAD) cmd = CMD_LOAD_RELOAD;
      else if (masked == A_STOP)   cmd = CMD_STOP;
      else if (masked == A_START)  cmd = CMD_START;
    end
  end

endmodule

// File: rtl/irq_line_qualify.sv
module irq_line_qualify
  import irq_ctr_pkg::*;
#(
  parameter int LINE_W    = 9,
  parameter int LAST_LINE = 239
) (
  input  logic              tick,
  input  logic [LINE_W-1:0] line,
  input  logic              render,
  input  logic              enabled,
  input  logic              pending,
  input  cpu_cmd_e          cmd,
  output logic              step,
  output logic              first_line
);

  localparam logic [LINE_W-1:0] LAST = LINE_W'(LAST_LINE);

  logic visible;

  always_comb begin
    visible    = (line <= LAST) && render;
    step       = tick && visible && enabled && !pending && (cmd == CMD_NONE);
    first_line = (line == '0);
  end

endmodule

// File: rtl/irq_count_core.sv
module irq_count_core
  import irq_ctr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  cpu_cmd_e         cmd,
  input  logic [CNT_W-1:0] wdata,
  input  logic             step,
  input  logic             first_line,
  output logic [CNT_W-1:0] count_q,
  output logic [CNT_W-1:0] reload_q,
  output logic             enable_q,
  output logic             pending_q
);

  step_res_t res;

  always_comb res = count_step(count_q, first_line);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q   <= '0;
      reload_q  <= '0;
      enable_q  <= 1'b0;
      pending_q <= 1'b0;
    end else begin
      unique case (cmd)
        CMD_LOAD_CNT: begin
          count_q   <= wdata;
          pending_q <= 1'b0;
        end
        CMD_LOAD_RELOAD: begin
          reload_q  <= wdata;
          pending_q <= 1'b0;
        end
        CMD_STOP: begin
          enable_q  <= 1'b0;
          pending_q <= 1'b0;
        end
        CMD_START: begin
          enable_q  <= 1'b1;
          pending_q <= 1'b0;
        end
        default: begin
          if (step) begin
            if (res.expire) begin
              pending_q <= 1'b1;
              count_q   <= reload_q;
            end else begin
              count_q   <= res.next;
            end
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/scanline_irq_counter.sv
module scanline_irq_counter
  import irq_ctr_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int LINE_W    = 9,
  parameter int LAST_LINE = 239
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_wr,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [CNT_W-1:0]  cpu_wdata,
  input  logic              line_tick,
  input  logic [LINE_W-1:0] line_index,
  input  logic              render_en,
  output logic              irq_out
);

  cpu_cmd_e         cmd;
  logic             line_step;
  logic             first_line;
  logic [CNT_W-1:0] count_q;
  logic [CNT_W-1:0] reload_q;
  logic             enable_q;
  logic             pending_q;

  irq_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .wr   (cpu_wr),
    .addr (cpu_addr),
    .cmd  (cmd)
  );

  irq_line_qualify #(.LINE_W(LINE_W), .LAST_LINE(LAST_LINE)) u_qual (
    .tick       (line_tick),
    .line       (line_index),
    .render     (render_en),
    .enabled    (enable_q),
    .pending    (pending_q),
    .cmd        (cmd),
    .step       (line_step),
    .first_line (first_line)
  );

  irq_count_core u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd        (cmd),
    .wdata      (cpu_wdata),
    .step       (line_step),
    .first_line (first_line),
    .count_q    (count_q),
    .reload_q   (reload_q),
    .enable_q   (enable_q),
    .pending_q  (pending_q)
  );

  assign irq_out = pending_q;

endmodule

// File: rtl/scanline_irq_checker.sv
module scanline_irq_checker
  import irq_ctr_pkg::*;
#(
  parameter int LINE_W    = 9,
  parameter int LAST_LINE = 239
) (
  input logic              clk,
  input logic              rst_n,
  input cpu_cmd_e          cmd,
  input logic              line_tick,
  input logic [LINE_W-1:0] line_index,
  input logic              render_en,
  input logic              line_step,
  input logic [CNT_W-1:0]  count_q,
  input logic [CNT_W-1:0]  reload_q,
  input logic              enable_q,
  input logic              irq_out
);

  AST_ACK_DROPS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd != CMD_NONE) |=> !irq_out); // R3

  AST_IRQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_out && cmd == CMD_NONE) |=> irq_out); // R8

  AST_NO_STEP_WHILE_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> !line_step); // R8

  AST_RISE_NEEDS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_out) |-> $past(line_step)); // R6

  AST_RELOAD_ON_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_out) |-> (count_q == reload_q)); // R6

  AST_STOPPED_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable_q && cmd == CMD_NONE) |=> ($stable(count_q) && !$rose(irq_out))); // R4

  AST_HIDDEN_LINE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (line_tick && (line_index > LINE_W'(LAST_LINE) || !render_en)) |-> !line_step); // R5

  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd != CMD_NONE) |-> !line_step); // R9

endmodule

bind scanline_irq_counter scanline_irq_checker #(
  .LINE_W(LINE_W), .LAST_LINE(LAST_LINE)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd        (cmd),
  .line_tick  (line_tick),
  .line_index (line_index),
  .render_en  (render_en),
  .line_step  (line_step),
  .count_q    (count_q),
  .reload_q   (reload_q),
  .enable_q   (enable_q),
  .irq_out    (irq_out)
);

// File: tb/scanline_irq_counter_tb_top.sv
`timescale 1ns/1ps
module scanline_irq_counter_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cpu_wr = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0] cpu_wdata = '0;
  logic       line_tick = 1'b0;
  logic [8:0] line_index = '0;
  logic       render_en = 1'b0;
  logic       irq_out;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  // behavioural reference state
  int  m_cnt = 0, m_rel = 0;
  bit  m_en = 0, m_pend = 0;

  always #10 clk = ~clk;

  scanline_irq_counter dut_i (
    .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .line_tick(line_tick), .line_index(line_index),
    .render_en(render_en), .irq_out(irq_out)
  );

  task automatic check(input string tag, input bit exp);
    n_tests++;
    if (irq_out !== exp) begin
      n_fail++;
      $display("FAIL %s: irq_out=%0b expected %0b at %0t", tag, irq_out, exp, $time);
    end
  endtask

  function automatic void model_step(input bit we, input int addr, input int data,
                                     input bit tick, input int line, input bit rend);
    int a = addr & 'hF7FF;
    bool_hit: begin end
    if (we && (a == 'hC000 || a == 'hC001 || a == 'hE000 || a == 'hE001)) begin
      m_pend = 0;
      if (a == 'hC000) m_cnt = data;
      if (a == 'hC001) m_rel = data;
      if (a == 'hE000) m_en = 0;
      if (a == 'hE001) m_en = 1;
    end else if (tick && line >= 0 && line < 240 && rend && m_en && !m_pend) begin
      int c = m_cnt;
      if (line == 0 && c > 0) c = c - 1;
      if (c == 0) begin
        m_pend = 1;
        m_cnt  = m_rel;
      end else begin
        m_cnt = c - 1;
      end
    end
  endfunction

  // one clock: drive after negedge, model at posedge, compare at next negedge
  task automatic cyc(input string tag, input bit we, input int addr, input int data,
                     input bit tick, input int line, input bit rend);
    cpu_wr = we; cpu_addr = addr[15:0]; cpu_wdata = data[7:0];
    line_tick = tick; line_index = line[8:0]; render_en = rend;
    @(posedge clk);
    model_step(we, addr, data, tick, line, rend);
    @(negedge clk);
    check(tag, m_pend);
  endtask

  task automatic wr(input string tag, input int addr, input int data);
    cyc(tag, 1, addr, data, 0, 0, 0);
  endtask

  task automatic ln(input string tag, input int line, input bit rend);
    cyc(tag, 0, 0, 0, 1, line, rend);
  endtask

  task automatic idle(input string tag);
    cyc(tag, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset", 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", 0);

    // R1: zero counter after reset expires on the first counted line
    wr("R4 start", 'hE001, 0);
    ln("R1 zero count expires", 5, 1);
    idle("R8 held");
    wr("R3 ack via start", 'hE001, 0);

    // R2 / R6: reload 3, counter 2
    wr("R2 load reload", 'hC001, 3);
    wr("R2 load count", 'hC000, 2);
    ln("R6 2->1", 10, 1);
    ln("R6 1->0", 11, 1);
    ln("R6 zero expires", 12, 1);
    ln("R8 no count while pending", 13, 1);
    ln("R8 still pending", 14, 1);
    wr("R3 ack via reload write", 'hC001, 3);
    // counter now 3 from reload
    ln("R5 line 240 ignored", 240, 1);
    ln("R5 render off ignored", 20, 0);
    ln("R5 line 300 ignored", 300, 1);
    // R7: scanline 0 with counter 3 -> 1
    ln("R7 extra decrement", 0, 1);
    ln("R7 1->0", 1, 1);
    ln("R7 expires on line 2", 2, 1);
    wr("R3 ack via stop", 'hE000, 0);

    // R4: stopped, lines do nothing
    wr("R2 mirror count load", 'hC800, 1);
    ln("R4 stopped", 0, 1);
    ln("R4 stopped", 3, 1);
    ln("R4 stopped", 4, 1);
    wr("R4 start mirror", 'hE801, 0);
    // R7: counter 1 on line 0 expires at once
    ln("R7 counter 1 on line 0", 0, 1);
    wr("R3 ack via count write", 'hC000, 2);

    // R9: write and tick together, tick dropped
    cyc("R9 write wins", 1, 'hC000, 1, 1, 50, 1);
    ln("R9 1->0", 51, 1);
    cyc("R9 reload write drops tick", 1, 'hC801, 7, 1, 52, 1);
    ln("R6 expires after dropped tick", 53, 1);
    wr("R3 ack via stop mirror", 'hE800, 0);

    // R10: near-miss addresses
    wr("R4 start", 'hE001, 0);
    wr("R10 load counter 0", 'hC000, 0);
    wr("R10 A000 ignored", 'hA000, 9);
    wr("R10 C002 ignored", 'hC002, 9);
    wr("R10 E002 ignored", 'hE002, 0);
    ln("R10 counter still zero", 100, 1);
    wr("R10 8001 no ack", 'h8001, 0);
    wr("R10 D000 no ack", 'hD000, 0);
    idle("R8 held after foreign writes");
    wr("R3 final ack", 'hE000, 0);
    wr("R10 F001 no start", 'hF001, 0);
    ln("R4 still stopped", 7, 1);

    // long count, reload 7 then count down
    wr("R4 start", 'hE001, 0);
    for (int i = 0; i < 9; i++) ln("R6 reload run", 20 + i, 1);
    wr("R3 ack", 'hE001, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule